// File: doc/BRIEF.md
# Segmented Speculative Wide Adder

This block adds two wide unsigned operands and a carry-in, producing a sum of the operand width and a carry-out. The operand is cut into K segments whose widths are listed in a parameter array. Each segment above the lowest one works out, in parallel, what its carry-out would be for an incoming carry of 0 and of 1. The lowest segment is added directly with the global carry-in.

The two speculative carry vectors are then added on one short ripple chain. The real segment carries are recovered from that chain's sum bits. A final stage builds each segment's result from its true incoming carry. A parameter picks one of three final stages. The first keeps both speculative sums and multiplexes between them. The second keeps only the carry-in-0 sum and increments it. The third keeps the raw operands and adds them again.

An optional register level sits between the speculative stage and carry resolution. It gives one cycle of latency.

Top module: `spec_wide_adder`

## Requirements
- R1: In every arrangement, {cout_o, sum_o} equals the full-width unsigned sum x_i + y_i + cin_i, with cout_o as the carry out of bit W-1.
- R2: Segment 0 (the lowest SEG_W[0] bits) is added with cin_i itself. Its carry-out is the carry into segment 1. A carry entering at bit 0 must ripple through every segment.
- R3: The speculative carry of segment k for an incoming carry of 1 is 1 exactly when the segment's x slice is at least the bitwise inverse of its y slice (unsigned compare at the segment width).
- R4: The speculative carry of segment k for an incoming carry of 0 is 1 exactly when the x slice is strictly greater than the inverted y slice. It is never 1 while the carry-in-1 speculative carry is 0.
- R5: A resolved segment carry follows three cases. It is 0 when both speculative carries are 0. It is 1 when both are 1. It equals the resolved carry of the segment below when only the carry-in-1 speculative carry is 1.
- R6: With ARCH = ARCH_SEL_MUX (value 0), each segment chooses between its stored x+y and x+y+1 sums, using the resolved incoming carry.
- R7: With ARCH = ARCH_CMP_INC (value 1), each segment stores only its x+y sum and adds the resolved incoming carry to it.
- R8: With ARCH = ARCH_CMP_ADD (value 2), each segment stores its operand slices and outputs x+y plus the resolved incoming carry.
- R9: With PIPE = 0 the outputs follow the inputs in the same cycle. With PIPE = 1, the outputs after a rising clock edge reflect the inputs present at that edge, and they do not change until the next edge.
- R10: With PIPE = 1, while rst_n is low, sum_o and cout_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register level |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_i | input | W | First operand |
| y_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Sum, modulo 2^W |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The segment widths must add up to W; elaboration stops otherwise. The checks on carry resolution and on the comparator pair assume reset has been released and that the operand inputs are stable when sampled. The bench changes inputs only on the falling edge and holds reset low through its first cycles. Stimulus targets segment boundaries directly. It includes slices where x equals the inverse of y, carries generated at a segment's top bit, and alternating patterns that propagate through every segment. Random operands cover the rest.

// File: rtl/spadd_pkg.sv
package spadd_pkg;

  typedef enum logic [1:0] {
    ARCH_SEL_MUX = 2'd0,
    ARCH_CMP_INC = 2'd1,
    ARCH_CMP_ADD = 2'd2
  } arch_e;

  // Recover the true carry out of a segment from the resolution chain sum bit.
  // kill (0,0) -> 0, generate (1,1) -> 1, propagate (0,1) -> inverse of sum bit
  function automatic logic recover_carry(logic spec_lo, logic spec_hi, logic chain_sum);
    return spec_lo | (spec_hi & ~chain_sum);
  endfunction

endpackage

// File: rtl/spadd_spec_seg.sv
module spadd_spec_seg
  import spadd_pkg::*;
#(
  parameter int unsigned WS   = 8,
  parameter arch_e       ARCH = ARCH_CMP_ADD,
  localparam int unsigned DW  = (ARCH == ARCH_CMP_INC) ? WS : 2 * WS
) (
  input  logic          rst_n,
  input  logic [WS-1:0] x,
  input  logic [WS-1:0] y,
  output logic          c_lo,
  output logic          c_hi,
  output logic [DW-1:0] keep
);

  if (ARCH == ARCH_SEL_MUX) begin : g_two_sums
    logic [WS:0] sum_lo, sum_hi;
    assign sum_lo = {1'b0, x} + {1'b0, y};
    assign sum_hi = {1'b0, x} + {1'b0, y} + (WS+1)'(1);
    assign c_lo   = sum_lo[WS];
    assign c_hi   = sum_hi[WS];
    assign keep   = {sum_hi[WS-1:0], sum_lo[WS-1:0]};
  end else if (ARCH == ARCH_CMP_INC) begin : g_one_sum
    logic [WS:0] sum_lo;
    assign sum_lo = {1'b0, x} + {1'b0, y};
    assign c_lo   = sum_lo[WS];
    assign c_hi   = (x >= ~y);
    assign keep   = sum_lo[WS-1:0];
  end else begin : g_two_cmp
    assign c_lo = (x > ~y);
    assign c_hi = (x >= ~y);
    assign keep = {y, x};
  end

  always_comb begin
    if (rst_n) begin
      assert_lo_implies_hi_R4: assert (!c_lo || c_hi);
    end
  end

endmodule

// File: rtl/spadd_carry_resolve.sv
module spadd_carry_resolve
  import spadd_pkg::*;
#(
  parameter int unsigned NB = 3
) (
  input  logic          rst_n,
  input  logic          c_in,
  input  logic [NB-1:0] c_lo,
  input  logic [NB-1:0] c_hi,
  output logic [NB-1:0] c_out
);

  logic [NB:0]   chain;
  logic [NB-1:0] below;

  // Short ripple chain over the speculative carry vectors
  assign chain = {1'b0, c_lo} + {1'b0, c_hi} + {{NB{1'b0}}, c_in};

  for (genvar i = 0; i < NB; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign below[i] = c_in;
    end else begin : g_rest
      assign below[i] = c_out[i-1];
    end
    assign c_out[i] = recover_carry(c_lo[i], c_hi[i], chain[i]);

    always_comb begin
      if (rst_n) begin
        assert_kill_R5:      assert (c_lo[i] || c_hi[i] || !c_out[i]);
        assert_generate_R5:  assert (!(c_lo[i] && c_hi[i]) || c_out[i]);
        assert_propagate_R5: assert (!(!c_lo[i] && c_hi[i]) || (c_out[i] == below[i]));
      end
    end
  end

endmodule

// File: rtl/spadd_final_seg.sv
module spadd_final_seg
  import spadd_pkg::*;
#(
  parameter int unsigned WS   = 8,
  parameter arch_e       ARCH = ARCH_CMP_ADD,
  localparam int unsigned DW  = (ARCH == ARCH_CMP_INC) ? WS : 2 * WS
) (
  input  logic          c_in,
  input  logic [DW-1:0] keep,
  output logic [WS-1:0] sum
);

  if (ARCH == ARCH_SEL_MUX) begin : g_mux
    assign sum = c_in ? keep[2*WS-1:WS] : keep[WS-1:0];
  end else if (ARCH == ARCH_CMP_INC) begin : g_inc
    assign sum = keep + {{(WS-1){1'b0}}, c_in};
  end else begin : g_add
    assign sum = keep[WS-1:0] + keep[2*WS-1:WS] + {{(WS-1){1'b0}}, c_in};
  end

endmodule

// File: rtl/spec_wide_adder.sv
module spec_wide_adder
  import spadd_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned K          = 4,
  parameter int unsigned SEG_W [K]  = '{10, 6, 7, 9},
  parameter arch_e       ARCH       = ARCH_SEL_MUX,
  parameter bit          PIPE       = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  function automatic int unsigned bit_lo(int unsigned idx);
    int unsigned acc = 0;
    for (int unsigned j = 0; j < idx; j++) acc += SEG_W[j];
    return acc;
  endfunction

  function automatic int unsigned keep_w(int unsigned idx);
    return (ARCH == ARCH_CMP_INC) ? SEG_W[idx] : 2 * SEG_W[idx];
  endfunction

  function automatic int unsigned keep_lo(int unsigned idx);
    int unsigned acc = 0;
    for (int unsigned j = 1; j < idx; j++) acc += keep_w(j);
    return acc;
  endfunction

  localparam int unsigned W0       = SEG_W[0];
  localparam int unsigned NB       = K - 1;
  localparam int unsigned KEEP_TOT = keep_lo(K);
  localparam int unsigned LO_B     = W0 + 1;
  localparam int unsigned HI_B     = LO_B + NB;
  localparam int unsigned KP_B     = HI_B + NB;
  localparam int unsigned ST_W     = KP_B + KEEP_TOT;

  if (bit_lo(K) != W || K < 2) begin : g_bad_layout
    $error("segment widths must total W and K must be at least 2");
  end

  // ---------------- speculative stage ----------------
  logic [ST_W-1:0] st_d, st_q;
  logic [W0:0]     seg0_sum;

  // R2: lowest segment takes the global carry-in directly
  assign seg0_sum          = {1'b0, x_i[W0-1:0]} + {1'b0, y_i[W0-1:0]} + {{W0{1'b0}}, cin_i};
  assign st_d[W0:0]        = seg0_sum;

  for (genvar k = 1; k < K; k++) begin : g_spec
    localparam int unsigned LO = bit_lo(k);
    localparam int unsigned WS = SEG_W[k];
    localparam int unsigned DW = keep_w(k);
    localparam int unsigned KO = KP_B + keep_lo(k);
    spadd_spec_seg #(.WS(WS), .ARCH(ARCH)) u_spec (
      .rst_n (rst_n),
      .x     (x_i[LO +: WS]),
      .y     (y_i[LO +: WS]),
      .c_lo  (st_d[LO_B + k - 1]),
      .c_hi  (st_d[HI_B + k - 1]),
      .keep  (st_d[KO +: DW])
    );
  end

  // ---------------- optional register level ----------------
  if (PIPE) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
    end
  end else begin : g_wire
    assign st_q = st_d;
  end

  // ---------------- carry resolution ----------------
  logic [NB-1:0] c_res;

  spadd_carry_resolve #(.NB(NB)) u_resolve (
    .rst_n (rst_n),
    .c_in  (st_q[W0]),
    .c_lo  (st_q[LO_B +: NB]),
    .c_hi  (st_q[HI_B +: NB]),
    .c_out (c_res)
  );

  // ---------------- final stage ----------------
  assign sum_o[W0-1:0] = st_q[W0-1:0];

  for (genvar k = 1; k < K; k++) begin : g_final
    localparam int unsigned LO = bit_lo(k);
    localparam int unsigned WS = SEG_W[k];
    localparam int unsigned DW = keep_w(k);
    localparam int unsigned KO = KP_B + keep_lo(k);
    logic c_into;
    if (k == 1) begin : g_from_seg0
      assign c_into = st_q[W0];
    end else begin : g_from_chain
      assign c_into = c_res[k-2];
    end
    spadd_final_seg #(.WS(WS), .ARCH(ARCH)) u_final (
      .c_in (c_into),
      .keep (st_q[KO +: DW]),
      .sum  (sum_o[LO +: WS])
    );
  end

  assign cout_o = c_res[NB-1];

  // ---------------- end-to-end checks ----------------
  if (PIPE) begin : g_chk_pipe
    assert_pipe_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ({cout_o, sum_o} ==
                 $past({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i})));
    assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |-> (sum_o == '0 && !cout_o));
  end else begin : g_chk_comb
    always_comb begin
      if (rst_n) begin
        assert_sum_exact_R1: assert ({cout_o, sum_o} ==
          {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i});
      end
    end
  end

endmodule

// File: tb/spec_wide_adder_tb_top.sv
module spec_wide_adder_tb_top;
  import spadd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int NDUT       = 6;
  localparam int NVEC       = 12;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] x     = '0;
  logic [W-1:0] y     = '0;
  logic         ci    = 1'b0;
  logic [W-1:0] sum_w  [NDUT];
  logic         cout_w [NDUT];

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // DUT 0..2: combinational, DUT 3..5: one register level
  spec_wide_adder #(.ARCH(ARCH_SEL_MUX), .PIPE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y), .cin_i(ci), .sum_o(sum_w[0]), .cout_o(cout_w[0]));
  spec_wide_adder #(.ARCH(ARCH_CMP_INC), .PIPE(1'b0)) dut_inc_c (
    .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y), .cin_i(ci), .sum_o(sum_w[1]), .cout_o(cout_w[1]));
  spec_wide_adder #(.ARCH(ARCH_CMP_ADD), .PIPE(1'b0)) dut_add_c (
    .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y), .cin_i(ci), .sum_o(sum_w[2]), .cout_o(cout_w[2]));
  spec_wide_adder #(.ARCH(ARCH_SEL_MUX), .PIPE(1'b1)) dut_mux_p (
    .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y), .cin_i(ci), .sum_o(sum_w[3]), .cout_o(cout_w[3]));
  spec_wide_adder #(.ARCH(ARCH_CMP_INC), .PIPE(1'b1)) dut_inc_p (
    .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y), .cin_i(ci), .sum_o(sum_w[4]), .cout_o(cout_w[4]));
  spec_wide_adder #(.ARCH(ARCH_CMP_ADD), .PIPE(1'b1)) dut_add_p (
    .clk(clk), .rst_n(rst_n), .x_i(x), .y_i(y), .cin_i(ci), .sum_o(sum_w[5]), .cout_o(cout_w[5]));

  // Reference: plain wide addition, carry in bit W
  function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b, logic c);
    logic [W:0] r;
    r = {1'b0, a};
    r = r + {1'b0, b};
    r = r + c;
    return r;
  endfunction

  function automatic logic [3*W+1:0] mk(logic [W-1:0] a, logic [W-1:0] b, logic c);
    return {a, b, c, ref_add(a, b, c)};
  endfunction

  // {x, y, cin, expected {cout,sum}}; segments are [9:0] [15:10] [22:16] [31:23]
  localparam logic [3*W+1:0] VEC [NVEC] = '{
    mk(32'h0000_0000, 32'h0000_0000, 1'b0),
    mk(32'hFFFF_FFFF, 32'h0000_0000, 1'b1),
    mk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1),
    mk(32'hAAAA_AAAA, 32'h5555_5555, 1'b1),
    mk(32'hAAAA_AAAA, 32'h5555_5555, 1'b0),
    mk(32'h1234_5678, 32'hEDCB_A987, 1'b0),
    mk(32'h1234_5678, 32'hEDCB_A987, 1'b1),
    mk(32'h0000_03FF, 32'h0000_0001, 1'b0),
    mk(32'hFFFF_FC00, 32'h0000_0400, 1'b0),
    mk(32'h007F_8000, 32'h0000_8000, 1'b0),
    mk(32'h8000_0000, 32'h8000_0000, 1'b0),
    mk(32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1)
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 2, 11: return "R1";
      1, 7:     return "R2";
      3, 4:     return "R5";
      5:        return "R4";
      6:        return "R3";
      default:  return "R5";
    endcase
  endfunction

  function automatic string mode_tag(int m);
    string s;
    case (m % 3)
      0:       s = "R6";
      1:       s = "R7";
      default: s = "R8";
    endcase
    if (m >= 3) s = {s, " R9"};
    return s;
  endfunction

  task automatic check(int m, logic [W:0] exp, string tag);
    logic [W:0] got;
    got = {cout_w[m], sum_w[m]};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s dut%0d: got %h expected %h", tag, mode_tag(m), m, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic c, string tag);
    @(negedge clk);
    x = a; y = b; ci = c;
    @(posedge clk);
    #1;
    for (int m = 0; m < NDUT; m++) check(m, ref_add(a, b, c), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset: registered copies stay at zero, combinational copies still add
    x = 32'hFFFF_FFFF; y = 32'h0000_0001; ci = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    for (int m = 3; m < NDUT; m++) check(m, '0, "R10");
    for (int m = 0; m < 3; m++) check(m, ref_add(x, y, ci), "R9");
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][3*W+1 -: W], VEC[i][2*W+1 -: W], VEC[i][W+1], vec_tag(i));
      for (int m = 0; m < NDUT; m++) check(m, VEC[i][W:0], vec_tag(i));
    end

    // Latency: registered output holds the previous result until the next edge (R9)
    @(negedge clk);
    x = 32'h0F0F_0F0F; y = 32'h1111_1111; ci = 1'b1;
    @(posedge clk);
    @(negedge clk);
    x = 32'h7FFF_FFFF; y = 32'h0000_0001; ci = 1'b0;
    #1;
    for (int m = 3; m < NDUT; m++) check(m, ref_add(32'h0F0F_0F0F, 32'h1111_1111, 1'b1), "R9");
    for (int m = 0; m < 3; m++) check(m, ref_add(32'h7FFF_FFFF, 32'h0000_0001, 1'b0), "R9");
    @(posedge clk); #1;
    for (int m = 3; m < NDUT; m++) check(m, ref_add(32'h7FFF_FFFF, 32'h0000_0001, 1'b0), "R9");

    // Boundary: each segment slice equal to the inverse of the other operand (R3, R4)
    apply(32'h0000_FC00, 32'hFFFF_03FF, 1'b1, "R3");
    apply(32'h0000_FC00, 32'hFFFF_03FF, 1'b0, "R4");
    // Carry generated at the top of segment 2 only
    apply(32'h0040_0000, 32'h0040_0000, 1'b0, "R5");

    // Random operands
    for (int i = 0; i < 300; i++) begin
      apply($urandom, $urandom, 1'($urandom), "R1");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule